// File: doc/BRIEF.md
# Dynamic Column Redundancy Shifter

This block sits between a cache's data path and one SRAM row of that cache, where the row is one bit wider than the data word. Each set has a stored repair position that names one faulty column, normally found by a self-test at boot once the supply voltage has been set. When a word is written, every bit at or above the repair position moves up one column. The faulty column is skipped, and the top data bit lands in the spare column. When a word is read, the opposite shift puts the bits back in order and drops whatever the faulty column holds. A single bad bit per set is therefore routed around by a multiplexer shift, and the line does not have to be taken out of service.

The repair positions are held in a small per-set table, loaded through a configuration write port. The table is read with the same set index as the data access, and both shift paths are purely combinational. One repair code, equal to the data width, means "no fault": the word passes straight through and the spare column is written with zero. Any larger code is treated the same way. A parameter selects between two equivalent netlist styles for the shifters: a thermometer-mask form and a per-bit multiplexer form.

Top module: `dcr_shift_top`

## Requirements
- R1: After reset, every set's repair position reads back on `cur_red_addr` as the no-fault code, equal to DATA_W (8 by default).
- R2: A cycle with `cfg_we` high stores `cfg_addr` as the repair position of set `cfg_set`. From the next cycle on it appears on `cur_red_addr` whenever `acc_set` selects that set. The other sets keep their values.
- R3: With repair position a < DATA_W, physical bit i equals data bit i for every i < a.
- R4: With repair position a < DATA_W, physical bit i+1 equals data bit i for every i >= a, and the faulty physical column a is driven with 0.
- R5: With a repair position >= DATA_W, `phys_wdata` equals {1'b0, wdata}: the word passes straight through and the spare column (bit DATA_W) stays 0.
- R6: With repair position a < DATA_W, `rdata[i]` is `phys_rdata[i]` for i < a and `phys_rdata[i+1]` for i >= a. With a repair position >= DATA_W, `rdata` is `phys_rdata[DATA_W-1:0]`, and the spare bit has no effect.
- R7: The value read from the faulty physical column (bit a, when a < DATA_W) has no effect on `rdata`.
- R8: For every repair position, with that column stuck at 0 or at 1 in the SRAM, writing a word and reading it back returns the same word.
- R9: The data paths are combinational and use the repair position of the set on `acc_set` in the same cycle, with no clock latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the repair-position table |
| rst | input | 1 | Synchronous active-high reset; loads every set with the no-fault code |
| cfg_we | input | 1 | Write strobe for the repair-position table |
| cfg_set | input | SW | Set whose repair position is written |
| cfg_addr | input | AW | Repair position to store (DATA_W or more means no fault) |
| acc_set | input | SW | Set index of the current data access |
| wdata | input | DATA_W | Logical word to be written |
| phys_wdata | output | DATA_W+1 | Shifted word driven to the SRAM row |
| phys_rdata | input | DATA_W+1 | Raw word read from the SRAM row |
| rdata | output | DATA_W | Logical word restored from `phys_rdata` |
| cur_red_addr | output | AW | Repair position of the set selected by `acc_set` |

## Verification
On every cycle the assertions check the following:
- bits below the repair position pass straight through on a write;
- the faulty column is written with zero;
- the no-fault codes leave the spare column idle;
- a physical word fed back unchanged restores the logical word;
- a table write becomes visible one cycle later;
- the table starts clean after reset.

Other behaviour only the bench scenarios can show. These are the round trips through a column that is really stuck at 0 or at 1, the fact that the faulty column's read value changes nothing, the exact unshift of arbitrary physical words, and the independence of the sets in the table. The bench covers them by sweeping every repair position, both stuck values and all data words.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
   // Netlist style of the two shifters; both give the same function.
   typedef enum logic [0:0] {
      DCR_MASK   = 1'b0,
      DCR_PERBIT = 1'b1
   } dcr_style_e;

   // Width needed for a repair position, including the no-fault code.
   function automatic int pos_width(input int data_w);
      return $clog2(data_w + 1);
   endfunction

   function automatic int set_width(input int sets);
      return (sets > 1) ? $clog2(sets) : 1;
   endfunction
endpackage

// File: rtl/dcr_addr_store.sv
module dcr_addr_store #(
   parameter int DATA_W = 8,
   parameter int SETS   = 4,
   parameter int AW     = dcr_pkg::pos_width(DATA_W),
   parameter int SW     = dcr_pkg::set_width(SETS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [SW-1:0] wr_set,
   input  logic [AW-1:0] wr_pos,
   input  logic [SW-1:0] rd_set,
   output logic [AW-1:0] rd_pos
);
   localparam logic [AW-1:0] CLEAN = AW'(DATA_W);

   logic [AW-1:0] table_q [SETS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < SETS; s++) table_q[s] <= CLEAN;
      end else if (wr_en && (int'(wr_set) < SETS)) begin
         table_q[wr_set] <= wr_pos;
      end
   end

   always_comb begin
      rd_pos = CLEAN;
      for (int s = 0; s < SETS; s++) begin
         if (int'(rd_set) == s) rd_pos = table_q[s];
      end
   end
endmodule

// File: rtl/dcr_mask_gen.sv
module dcr_mask_gen #(
   parameter int DATA_W = 8,
   parameter int AW     = dcr_pkg::pos_width(DATA_W)
) (
   input  logic [AW-1:0]     pos,
   output logic [DATA_W-1:0] shift_mask
);
   localparam logic [AW-1:0] LIMIT = AW'(DATA_W);

   logic faulty;
   assign faulty = (pos < LIMIT);

   // Thermometer: ones from the faulty position upward.
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam logic [AW-1:0] IDX = AW'(i);
      assign shift_mask[i] = faulty & (pos <= IDX);
   end
endmodule

// File: rtl/dcr_wr_shift.sv
module dcr_wr_shift #(
   parameter int                  DATA_W = 8,
   parameter dcr_pkg::dcr_style_e STYLE  = dcr_pkg::DCR_MASK
) (
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] shift_mask,
   output logic [DATA_W:0]   dout
);
   if (STYLE == dcr_pkg::DCR_MASK) begin : g_mask
      assign dout = {1'b0, din & ~shift_mask} | {din & shift_mask, 1'b0};
   end else begin : g_perbit
      assign dout[0] = shift_mask[0] ? 1'b0 : din[0];
      for (genvar i = 1; i < DATA_W; i++) begin : g_col
         assign dout[i] = shift_mask[i-1] ? din[i-1]
                        : (shift_mask[i] ? 1'b0 : din[i]);
      end
      assign dout[DATA_W] = shift_mask[DATA_W-1] ? din[DATA_W-1] : 1'b0;
   end
endmodule

// File: rtl/dcr_rd_unshift.sv
module dcr_rd_unshift #(
   parameter int                  DATA_W = 8,
   parameter dcr_pkg::dcr_style_e STYLE  = dcr_pkg::DCR_MASK
) (
   input  logic [DATA_W:0]   pin,
   input  logic [DATA_W-1:0] shift_mask,
   output logic [DATA_W-1:0] dout
);
   if (STYLE == dcr_pkg::DCR_MASK) begin : g_mask
      assign dout = (pin[DATA_W-1:0] & ~shift_mask) | (pin[DATA_W:1] & shift_mask);
   end else begin : g_perbit
      for (genvar i = 0; i < DATA_W; i++) begin : g_col
         assign dout[i] = shift_mask[i] ? pin[i+1] : pin[i];
      end
   end
endmodule

// File: rtl/dcr_shift_top.sv
module dcr_shift_top #(
   parameter int                  DATA_W = 8,
   parameter int                  SETS   = 4,
   parameter dcr_pkg::dcr_style_e STYLE  = dcr_pkg::DCR_MASK,
   parameter int                  AW     = dcr_pkg::pos_width(DATA_W),
   parameter int                  SW     = dcr_pkg::set_width(SETS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic [SW-1:0]     cfg_set,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [SW-1:0]     acc_set,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W:0]   phys_wdata,
   input  logic [DATA_W:0]   phys_rdata,
   output logic [DATA_W-1:0] rdata,
   output logic [AW-1:0]     cur_red_addr
);
   if (DATA_W < 2) begin : g_bad_width
      $error("dcr_shift_top: DATA_W must be at least 2");
   end
   if (SETS < 1) begin : g_bad_sets
      $error("dcr_shift_top: SETS must be at least 1");
   end
   if (AW < dcr_pkg::pos_width(DATA_W)) begin : g_bad_aw
      $error("dcr_shift_top: AW too narrow for the no-fault code");
   end
   if ((1 << SW) < SETS) begin : g_bad_sw
      $error("dcr_shift_top: SW too narrow for SETS");
   end

   logic [DATA_W-1:0] shift_mask;

   dcr_addr_store #(.DATA_W(DATA_W), .SETS(SETS), .AW(AW), .SW(SW)) u_store (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (cfg_we),
      .wr_set (cfg_set),
      .wr_pos (cfg_addr),
      .rd_set (acc_set),
      .rd_pos (cur_red_addr)
   );

   dcr_mask_gen #(.DATA_W(DATA_W), .AW(AW)) u_mask (
      .pos        (cur_red_addr),
      .shift_mask (shift_mask)
   );

   dcr_wr_shift #(.DATA_W(DATA_W), .STYLE(STYLE)) u_wr (
      .din        (wdata),
      .shift_mask (shift_mask),
      .dout       (phys_wdata)
   );

   dcr_rd_unshift #(.DATA_W(DATA_W), .STYLE(STYLE)) u_rd (
      .pin        (phys_rdata),
      .shift_mask (shift_mask),
      .dout       (rdata)
   );
endmodule

// File: rtl/dcr_shift_chk.sv
module dcr_shift_chk #(
   parameter int DATA_W = 8,
   parameter int AW     = 4,
   parameter int SW     = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              cfg_we,
   input logic [SW-1:0]     cfg_set,
   input logic [AW-1:0]     cfg_addr,
   input logic [SW-1:0]     acc_set,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W:0]   phys_wdata,
   input logic [DATA_W:0]   phys_rdata,
   input logic [DATA_W-1:0] rdata,
   input logic [AW-1:0]     cur_red_addr
);
   logic              has_fault;
   logic [DATA_W:0]   low_bits;
   logic [DATA_W:0]   fault_col;

   assign has_fault = (int'(cur_red_addr) < DATA_W);
   assign low_bits  = ((DATA_W+1)'(1) << cur_red_addr) - (DATA_W+1)'(1);
   assign fault_col = (DATA_W+1)'(1) << cur_red_addr;

   assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (int'(cur_red_addr) == DATA_W));

   assert_cfg_visible_R2: assert property (@(posedge clk) disable iff (rst)
      cfg_we |=> ((acc_set != $past(cfg_set)) || (cur_red_addr == $past(cfg_addr))));

   assert_low_pass_R3: assert property (@(posedge clk) disable iff (rst)
      has_fault |-> (((phys_wdata ^ {1'b0, wdata}) & low_bits) == '0));

   assert_fault_col_zero_R4: assert property (@(posedge clk) disable iff (rst)
      has_fault |-> ((phys_wdata & fault_col) == '0));

   assert_spare_idle_R5: assert property (@(posedge clk) disable iff (rst)
      !has_fault |-> (phys_wdata == {1'b0, wdata}));

   assert_round_trip_R8: assert property (@(posedge clk) disable iff (rst)
      (phys_rdata == phys_wdata) |-> (rdata == wdata));
endmodule

bind dcr_shift_top dcr_shift_chk #(.DATA_W(DATA_W), .AW(AW), .SW(SW)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .cfg_we       (cfg_we),
   .cfg_set      (cfg_set),
   .cfg_addr     (cfg_addr),
   .acc_set      (acc_set),
   .wdata        (wdata),
   .phys_wdata   (phys_wdata),
   .phys_rdata   (phys_rdata),
   .rdata        (rdata),
   .cur_red_addr (cur_red_addr)
);

// File: tb/sim_dcr_shift_top.sv
`timescale 1ns/1ps
module sim_dcr_shift_top;
   localparam int W  = 8;
   localparam int NS = 4;
   localparam int AW = 4;
   localparam int SW = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_we = 1'b0;
   logic [SW-1:0] cfg_set = '0;
   logic [AW-1:0] cfg_addr = '0;
   logic [SW-1:0] acc_set = '0;
   logic [W-1:0]  wdata = '0;
   logic [W:0]    phys_wdata;
   logic [W:0]    phys_rdata = '0;
   logic [W-1:0]  rdata;
   logic [AW-1:0] cur_red_addr;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   dcr_shift_top #(.DATA_W(W), .SETS(NS)) u0 (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_set(cfg_set), .cfg_addr(cfg_addr),
      .acc_set(acc_set), .wdata(wdata), .phys_wdata(phys_wdata),
      .phys_rdata(phys_rdata), .rdata(rdata), .cur_red_addr(cur_red_addr)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_phys(input int a, input int d);
      if (a < W) return (d & ((1 << a) - 1)) | ((d >> a) << (a + 1));
      return d;
   endfunction

   function automatic int exp_read(input int a, input int p);
      if (a < W) return ((p & ((1 << a) - 1)) | ((p >> (a + 1)) << a)) & ((1 << W) - 1);
      return p & ((1 << W) - 1);
   endfunction

   task automatic cfg_write(input int s, input int a);
      @(negedge clk);
      cfg_we = 1'b1; cfg_set = SW'(s); cfg_addr = AW'(a);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: clean table after reset, word passes straight through
      for (int s = 0; s < NS; s++) begin
         acc_set = SW'(s); wdata = 8'hFF; #1;
         check(int'(cur_red_addr) == W, "R1 reset code", int'(cur_red_addr), W);
         check(int'(phys_wdata) == 'h0FF, "R1/R5 reset pass", int'(phys_wdata), 'h0FF);
      end
      // R2: per-set independence
      cfg_write(1, 3);
      cfg_write(2, 6);
      @(negedge clk);
      for (int s = 0; s < NS; s++) begin
         int e;
         e = (s == 1) ? 3 : ((s == 2) ? 6 : W);
         acc_set = SW'(s); #1;
         check(int'(cur_red_addr) == e, "R2 set table", int'(cur_red_addr), e);
      end
      // R9: switching the set alone changes the mapping with no clock edge
      @(negedge clk);
      wdata = 8'hA5; acc_set = 2'd1; #0.5;
      check(int'(phys_wdata) == exp_phys(3, 'hA5), "R9 same-cycle set1",
            int'(phys_wdata), exp_phys(3, 'hA5));
      acc_set = 2'd2; #0.5;
      check(int'(phys_wdata) == exp_phys(6, 'hA5), "R9 same-cycle set2",
            int'(phys_wdata), exp_phys(6, 'hA5));
      // Full sweep: every repair code, both stuck values, all words
      for (int k = 0; k <= W + 1; k++) begin
         int a;
         int s;
         a = (k <= W) ? k : 12;
         s = k % NS;
         cfg_write(s, a);
         acc_set = SW'(s); #1;
         check(int'(cur_red_addr) == a, "R2 write visible", int'(cur_red_addr), a);
         for (int sv = 0; sv < 2; sv++) begin
            for (int d = 0; d < (1 << W); d++) begin
               int st;
               int p;
               wdata = W'(d); #0.25;
               if (a < W)
                  check(int'(phys_wdata) == exp_phys(a, d), "R3/R4 write shift",
                        int'(phys_wdata), exp_phys(a, d));
               else
                  check(int'(phys_wdata) == d, "R5 no-fault pass", int'(phys_wdata), d);
               st = int'(phys_wdata);
               if (a < W) st = sv ? (st | (1 << a)) : (st & ~(1 << a));
               phys_rdata = (W+1)'(st); #0.25;
               check(int'(rdata) == d, "R8 stuck round trip", int'(rdata), d);
               phys_rdata = (W+1)'(st ^ (1 << ((a < W) ? a : W))); #0.25;
               check(int'(rdata) == d, "R7 faulty column ignored", int'(rdata), d);
               p = (d * 37 + a * 11 + sv * 300) & ((1 << (W + 1)) - 1);
               phys_rdata = (W+1)'(p); #0.25;
               check(int'(rdata) == exp_read(a, p), "R6 read unshift",
                     int'(rdata), exp_read(a, p));
            end
         end
      end
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #900000;
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule